// File: doc/BRIEF.md
# Dual-Channel Timer Capture Unit

This block timestamps activity on one external input line. Two capture channels share that line. When its chosen event occurs, a channel copies the current value of a free-running 16-bit timer into its own capture register and raises its own sticky flag. The timer itself is supplied from outside the block.

Each channel has a 4-bit mode field, and both fields sit in one 8-bit control register. A channel can fire on every falling edge, on every rising edge, or on every 4th or 16th rising edge. The divided modes count rising edges in a per-channel prescaler. The prescaler is cleared only while the channel is out of capture mode, or by reset. A move between two capture modes keeps the count, so the first divided capture after such a move can arrive early.

The raw input is synchronized with two flops before any edge is detected. Software clears each flag with a one-cycle strobe.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset, both capture registers read 0, both flags read 0, and both channels are disabled (mode 0000).
- R2: A write with `ctrl_we` high loads `ctrl_wdata`. Bits 3:0 are the mode of channel 0 and bits 7:4 are the mode of channel 1. The new mode decides every event seen at the clock edge that follows the write edge.
- R3: Mode 0100 captures on every falling edge of the input. If the input changes between clock edges k-1 and k, the capture happens at edge k+2, and the register then holds the timer value present at that edge.
- R4: Mode 0101 captures on every rising edge, with the same latency as R3. Falling edges have no effect in this mode.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Counting starts from a cleared prescaler.
- R6: Modes 00xx (disabled) and 1xxx (non-capture) never capture and never change the register or the flag. While a channel is in one of these modes, its prescaler is held at zero.
- R7: Each capture sets the channel's flag. The flag stays set until a `flag_clr` strobe, and it reads 0 one edge after the strobe. If a capture and a strobe fall on the same edge, the flag stays set.
- R8: A new capture overwrites the held value even if the flag is still set. No overrun indication is given.
- R9: A change between capture modes keeps the prescaler count. A divided mode fires on the first rising edge at which the count is at least the ratio minus one, and the count then returns to zero. The two single-edge modes leave the count unchanged.
- R10: The channels are independent. One input edge can make either channel, both channels or neither channel capture, according to their own modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Asynchronous external event input |
| tmr_val | input | 16 | Free-running timer value to latch |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control data, two 4-bit mode fields |
| flag_clr | input | 2 | Per-channel flag clear strobes |
| cap_vals | output | 32 | Capture registers, channel 0 in bits 15:0 |
| cap_flag | output | 2 | Sticky per-channel capture flags |

## Verification
Each edge driven on `pin_raw` between clock edges k-1 and k produces its result at edge k+2: the capture register takes the timer value of that edge, and the flag sets on that same edge. A control write takes effect at its own edge. A flag clear shows one edge after the strobe. For every input edge, the driver stamps each expected item with the cycle in which the result must first be visible. The monitor compares at the falling clock edge of exactly that cycle. Because the timer advances every cycle, a capture that arrives one cycle early or late shows up as a value mismatch.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int CAP_MODE_W = 4;

  typedef enum logic [1:0] {
    EV_FALL  = 2'd0,
    EV_RISE  = 2'd1,
    EV_DIV_A = 2'd2,
    EV_DIV_B = 2'd3
  } ev_sel_e;

  // Upper mode bits 01 select a capture mode; everything else is idle.
  function automatic logic mode_captures(input logic [CAP_MODE_W-1:0] m);
    return m[CAP_MODE_W-1:CAP_MODE_W-2] == 2'b01;
  endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic rise_ev,
  output logic fall_ev
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_raw};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_ev =  sync_q[STAGES-1] & ~prev_q;
  assign fall_ev = ~sync_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/cap_ctrl_reg.sv
module cap_ctrl_reg #(
  parameter int NCH    = 2,
  parameter int MODE_W = 4,
  localparam int CTRL_W = NCH * MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] mode_vec
);

  always_ff @(posedge clk) begin
    if (rst)     mode_vec <= '0;
    else if (we) mode_vec <= wdata;
  end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int PRE_W = 4,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CAP_MODE_W-1:0] mode,
  input  logic                  rise_ev,
  input  logic                  fall_ev,
  input  logic [TMR_W-1:0]      tmr_val,
  input  logic                  flag_clr,
  output logic [TMR_W-1:0]      cap_val,
  output logic                  flag
);

  localparam logic [PRE_W-1:0] LIM_A = PRE_W'(DIV_A - 1);
  localparam logic [PRE_W-1:0] LIM_B = PRE_W'(DIV_B - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic             cap_en;
  logic             divided;
  logic [PRE_W-1:0] lim;
  logic             fire;
  ev_sel_e          sel;

  always_comb begin
    cap_en  = mode_captures(mode);
    sel     = ev_sel_e'(mode[1:0]);
    divided = (sel == EV_DIV_A) || (sel == EV_DIV_B);
    lim     = (sel == EV_DIV_B) ? LIM_B : LIM_A;
    fire    = 1'b0;
    if (cap_en) begin
      unique case (sel)
        EV_FALL:  fire = fall_ev;
        EV_RISE:  fire = rise_ev;
        default:  fire = rise_ev && (pre_cnt >= lim);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cap_en)           pre_cnt <= '0;
    else if (rise_ev && divided)  pre_cnt <= fire ? '0 : pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       cap_val <= '0;
    else if (fire) cap_val <= tmr_val;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (fire)     flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
  import cap_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16,
  localparam int CTRL_W     = NCH * CAP_MODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pin_raw,
  input  logic [TMR_W-1:0]     tmr_val,
  input  logic                 ctrl_we,
  input  logic [CTRL_W-1:0]    ctrl_wdata,
  input  logic [NCH-1:0]       flag_clr,
  output logic [NCH*TMR_W-1:0] cap_vals,
  output logic [NCH-1:0]       cap_flag
);

  logic              rise_ev;
  logic              fall_ev;
  logic [CTRL_W-1:0] mode_vec;

  cap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pin_raw),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  cap_ctrl_reg #(.NCH(NCH), .MODE_W(CAP_MODE_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we       (ctrl_we),
    .wdata    (ctrl_wdata),
    .mode_vec (mode_vec)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cap_channel #(
      .TMR_W (TMR_W),
      .PRE_W (PRE_W),
      .DIV_A (DIV_A),
      .DIV_B (DIV_B)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode_vec[g*CAP_MODE_W +: CAP_MODE_W]),
      .rise_ev  (rise_ev),
      .fall_ev  (fall_ev),
      .tmr_val  (tmr_val),
      .flag_clr (flag_clr[g]),
      .cap_val  (cap_vals[g*TMR_W +: TMR_W]),
      .flag     (cap_flag[g])
    );
  end

endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int NCH   = 2,
  parameter int TMR_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rise_ev,
  input logic                 fall_ev,
  input logic [NCH*4-1:0]     mode_vec,
  input logic [TMR_W-1:0]     tmr_val,
  input logic [NCH-1:0]       flag_clr,
  input logic [NCH*TMR_W-1:0] cap_vals,
  input logic [NCH-1:0]       cap_flag
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_FALL_CAPTURES: assert property (@(posedge clk) disable iff (rst)
      (fall_ev && mode_vec[g*4 +: 4] == 4'b0100) |=>
        (cap_flag[g] && cap_vals[g*TMR_W +: TMR_W] == $past(tmr_val))); // R3

    AST_RISE_CAPTURES: assert property (@(posedge clk) disable iff (rst)
      (rise_ev && mode_vec[g*4 +: 4] == 4'b0101) |=>
        (cap_flag[g] && cap_vals[g*TMR_W +: TMR_W] == $past(tmr_val))); // R4

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (mode_vec[g*4+3 -: 2] != 2'b01 && !flag_clr[g]) |=>
        ($stable(cap_vals[g*TMR_W +: TMR_W]) && $stable(cap_flag[g]))); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (cap_flag[g] && !flag_clr[g]) |=> cap_flag[g]); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[g] && !rise_ev && !fall_ev) |=> !cap_flag[g]); // R7

    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!rise_ev && !fall_ev) |=> $stable(cap_vals[g*TMR_W +: TMR_W])); // R8
  end

endmodule

bind dual_capture_unit cap_checker #(.NCH(NCH), .TMR_W(TMR_W)) u_cap_checker (
  .clk      (clk),
  .rst      (rst),
  .rise_ev  (rise_ev),
  .fall_ev  (fall_ev),
  .mode_vec (mode_vec),
  .tmr_val  (tmr_val),
  .flag_clr (flag_clr),
  .cap_vals (cap_vals),
  .cap_flag (cap_flag)
);

// File: tb/test_dual_capture_unit.sv
module test_dual_capture_unit;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          ch;
    logic [15:0] val;
    logic        flg;
    int          due;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_raw = 1'b0;
  logic [15:0] tmr_val;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [31:0] cap_vals;
  logic [1:0]  cap_flag;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  exp_t sb[$];
  exp_t e;

  logic [3:0]  m_mode [2];
  int          m_pre  [2];
  logic [15:0] m_cap  [2];
  logic        m_flag [2];

  function automatic logic [15:0] tval(input int c);
    return 16'(c * 7 + 32'h1234);
  endfunction

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tmr_val = tval(cyc);

  dual_capture_unit i_dual_capture_unit (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin_raw),
    .tmr_val    (tmr_val),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .flag_clr   (flag_clr),
    .cap_vals   (cap_vals),
    .cap_flag   (cap_flag)
  );

  // Monitor: compare results on the cycle they are due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      e = sb.pop_front();
      n_tests++;
      if (cap_vals[e.ch*16 +: 16] !== e.val || cap_flag[e.ch] !== e.flg) begin
        n_fail++;
        $display("FAIL %s ch%0d cycle %0d: cap=%h flag=%b expected cap=%h flag=%b",
                 e.req, e.ch, cyc, cap_vals[e.ch*16 +: 16], cap_flag[e.ch], e.val, e.flg);
      end
    end
  end

  task automatic set_mode(input logic [7:0] d);
    m_mode[0] = d[3:0];
    m_mode[1] = d[7:4];
    for (int ch = 0; ch < 2; ch++)
      if (m_mode[ch][3:2] != 2'b01) m_pre[ch] = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = d;
    set_mode(d);
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  // Driver: move the pin, predict both channels, push expectations.
  task automatic pin_to(input logic lvl, input logic [1:0] clrm, input bit wr,
                        input logic [7:0] wd, input string req);
    int c0;
    @(negedge clk);
    pin_raw = lvl;
    c0 = cyc;
    if (wr) begin
      ctrl_we = 1'b1;
      ctrl_wdata = wd;
      set_mode(wd);
    end
    for (int ch = 0; ch < 2; ch++) begin
      bit fire = 1'b0;
      int lim;
      if (m_mode[ch][3:2] != 2'b01) m_pre[ch] = 0;
      else begin
        case (m_mode[ch][1:0])
          2'd0: fire = !lvl;
          2'd1: fire = lvl;
          default: begin
            lim = (m_mode[ch][1:0] == 2'd2) ? 3 : 15;
            if (lvl) begin
              if (m_pre[ch] >= lim) begin fire = 1'b1; m_pre[ch] = 0; end
              else m_pre[ch]++;
            end
          end
        endcase
      end
      if (fire) begin
        m_cap[ch] = tval(c0 + 2);
        m_flag[ch] = 1'b1;
      end else if (clrm[ch]) begin
        m_flag[ch] = 1'b0;
      end
      sb.push_back('{ch, m_cap[ch], m_flag[ch], c0 + 3, req});
    end
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
    flag_clr = clrm;
    @(negedge clk);
    flag_clr = '0;
    @(negedge clk);
  endtask

  task automatic edge_to(input logic lvl, input string req);
    pin_to(lvl, 2'b00, 1'b0, 8'h00, req);
  endtask

  task automatic clear(input logic [1:0] mask);
    int c;
    @(negedge clk);
    flag_clr = mask;
    c = cyc;
    for (int ch = 0; ch < 2; ch++) begin
      if (mask[ch]) m_flag[ch] = 1'b0;
      sb.push_back('{ch, m_cap[ch], m_flag[ch], c + 1, "R7"});
    end
    @(negedge clk);
    flag_clr = '0;
  endtask

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      m_mode[ch] = 4'b0000; m_pre[ch] = 0; m_cap[ch] = '0; m_flag[ch] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_tests++;
    if (cap_vals !== '0 || cap_flag !== '0) begin
      n_fail++;
      $display("FAIL R1: cap=%h flag=%b expected cap=0 flag=00", cap_vals, cap_flag);
    end
    edge_to(1'b1, "R1"); // disabled after reset: nothing captured
    edge_to(1'b0, "R1");

    // R3 R4 R10: ch0 falling, ch1 rising
    wr_ctrl(8'h54);
    edge_to(1'b1, "R4");
    edge_to(1'b0, "R3");
    edge_to(1'b1, "R10");
    edge_to(1'b0, "R10");
    clear(2'b11);

    // R8: overwrite while flag still set
    edge_to(1'b1, "R8");
    edge_to(1'b0, "R8");
    edge_to(1'b1, "R8");
    edge_to(1'b0, "R8");

    // R5: divide by 4 on ch0, by 16 on ch1
    wr_ctrl(8'h76);
    for (int i = 0; i < 18; i++) begin
      edge_to(1'b1, "R5");
      edge_to(1'b0, "R5");
    end

    // R6: non-capture modes clear the prescaler and stay quiet
    wr_ctrl(8'h08);
    for (int i = 0; i < 3; i++) begin
      edge_to(1'b1, "R6");
      edge_to(1'b0, "R6");
    end

    // R9: ratio change keeps the count
    wr_ctrl(8'h70);
    for (int i = 0; i < 10; i++) begin
      edge_to(1'b1, "R9");
      edge_to(1'b0, "R9");
    end
    wr_ctrl(8'h66);
    for (int i = 0; i < 5; i++) begin
      edge_to(1'b1, "R9");
      edge_to(1'b0, "R9");
    end

    // R7: clear in the same cycle as a capture
    wr_ctrl(8'h55);
    clear(2'b11);
    pin_to(1'b1, 2'b11, 1'b0, 8'h00, "R7");
    pin_to(1'b0, 2'b01, 1'b0, 8'h00, "R7");

    // R2: write and edge together; new mode decides the edge
    pin_to(1'b1, 2'b00, 1'b1, 8'h44, "R2");
    pin_to(1'b0, 2'b00, 1'b0, 8'h00, "R2");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule